// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-bit register (the width is a parameter) that can keep its contents, shift toward the high end, shift toward the low end, or take a parallel word. A two-bit mode select picks the operation, and every update happens on the rising clock edge. An active-low reset clears the register at once, with no clock needed. The parallel input and the register output share one bidirectional bus. For synthesis that bus is split into an input word, an output word and a single drive-enable.

The bus driver is switched off by either of two active-low output enables. It also switches itself off in load mode, so that an outside source can place the word to be captured. Switching the driver off never stops the register from working.

The lowest and highest bits also come out on two serial taps. These taps are always driven, so registers can be chained into longer words. For a chain that shifts toward the high end, the high tap of one stage feeds the low serial input of the next. For a chain that shifts toward the low end, the low tap of the upper stage feeds the high serial input of the lower stage.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode 2'b00 (hold), a clock edge leaves the register unchanged, whatever the serial inputs and the bus carry.
- R2: With mode 2'b01 (shift up), a clock edge puts ser_in_lo into bit 0 and moves every bit n into bit n+1. The old top bit is lost.
- R3: With mode 2'b10 (shift down), a clock edge puts ser_in_hi into the top bit and moves every bit n into bit n-1. The old bit 0 is lost.
- R4: With mode 2'b11 (load), a clock edge copies bus_in[n] into bit n for every n.
- R5: While rst_n is low, all bits are zero. Clearing happens as soon as rst_n falls, without any clock edge, and mode and clock have no effect while reset is held.
- R6: bus_drive is high only when oe_a_n and oe_b_n are both low and mode is not 2'b11.
- R7: bus_out always shows the register contents, whatever the state of bus_drive. Hold, shift and load behave the same with the driver off as with it on.
- R8: tap_lo always equals bit 0 and tap_hi always equals the top bit, whatever the enable and mode states.
- R9: Two instances chained through their taps and serial inputs behave as one 16-bit register, shifting in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_hi | input | 1 | Serial bit entering the top bit on shift down |
| oe_a_n | input | 1 | Bus output enable, active low |
| oe_b_n | input | 1 | Bus output enable, active low |
| bus_in | input | WIDTH | Value seen on the shared bus, used by load |
| bus_out | output | WIDTH | Value to place on the shared bus (register contents) |
| bus_drive | output | 1 | High when the bus driver is on |
| tap_lo | output | 1 | Bit 0, always driven |
| tap_hi | output | 1 | Top bit, always driven |

## Verification
The register contents are visible on bus_out at all times, so a wrong bit caused by a mis-routed shift, a wrong load or a stuck hold shows up one edge after the faulty update. A wrong tap or a broken chain link shows up within one edge of the bad bit reaching an end of the word. In a 16-bit chain, a bad crossing between stages appears in the upper word on the first edge after the crossing. The driver enable is combinational, so a fault in its logic shows on bus_drive in the same cycle as the input change.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_next_calc.sv
`timescale 1ns/1ps
module usr_next_calc
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] down_val;

    // Per-bit neighbour selection for both shift directions
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        if (gi == 0) begin : g_low
            assign up_val[gi] = ser_lo;
        end else begin : g_low_n
            assign up_val[gi] = cur[gi-1];
        end
        if (gi == TOP) begin : g_high
            assign down_val[gi] = ser_hi;
        end else begin : g_high_n
            assign down_val[gi] = cur[gi+1];
        end
    end

    always_comb begin
        unique case (usr_mode_e'(mode))
            MODE_UP:   nxt = up_val;
            MODE_DOWN: nxt = down_val;
            MODE_LOAD: nxt = load_val;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/usr_drive_ctrl.sv
`timescale 1ns/1ps
module usr_drive_ctrl
    import usr_pkg::*;
(
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    input  logic [1:0] mode,
    output logic       drive
);
    logic enabled;
    logic loading;

    always_comb begin
        enabled = ~(oe_a_n | oe_b_n);
        loading = (usr_mode_e'(mode) == MODE_LOAD);
        drive   = enabled & ~loading;
    end
endmodule

// File: rtl/usr_shift_reg.sv
`timescale 1ns/1ps
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_drive,
    output logic             tap_lo,
    output logic             tap_hi
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [WIDTH-1:0] calc_nxt;

    usr_next_calc #(.WIDTH(WIDTH)) i_next (
        .mode     (mode),
        .cur      (st_q.bits),
        .ser_lo   (ser_in_lo),
        .ser_hi   (ser_in_hi),
        .load_val (bus_in),
        .nxt      (calc_nxt)
    );

    usr_drive_ctrl i_drive (
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .mode   (mode),
        .drive  (bus_drive)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = calc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_out = st_q.bits;
    assign tap_lo  = st_q.bits[0];
    assign tap_hi  = st_q.bits[TOP];

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> (bus_out == $past(bus_out)));

    p_shift_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP) |=> (bus_out == {$past(bus_out[TOP-1:0]), $past(ser_in_lo)}));

    p_shift_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN) |=> (bus_out == {$past(ser_in_hi), $past(bus_out[TOP:1])}));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (bus_out == $past(bus_in)));

    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |-> (bus_out == '0));

    p_drive_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n || mode == MODE_LOAD) |-> !bus_drive);

    p_drive_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && mode != MODE_LOAD) |-> bus_drive);
endmodule

// File: tb/test_usr_shift_reg.sv
`timescale 1ns/1ps
module test_usr_shift_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       sl = 1'b0;
    logic       sh = 1'b0;
    logic       oea = 1'b1;
    logic       oeb = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_drive;
    logic       tap_lo;
    logic       tap_hi;

    logic [1:0] c_mode = 2'b00;
    logic       c_ser_up = 1'b0;
    logic       c_ser_dn = 1'b0;
    logic [7:0] c_bus = 8'h00;
    logic [7:0] lo_out, hi_out;
    logic       lo_tlo, lo_thi, hi_tlo, hi_thi, lo_drv, hi_drv;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0]  model = 8'h00;
    logic [15:0] cmodel = 16'h0000;

    always #5 clk = ~clk;

    usr_shift_reg i_usr_shift_reg (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ser_in_lo(sl), .ser_in_hi(sh),
        .oe_a_n(oea), .oe_b_n(oeb), .bus_in(bus_in), .bus_out(bus_out),
        .bus_drive(bus_drive), .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    usr_shift_reg i_casc_lo (
        .clk(clk), .rst_n(rst_n), .mode(c_mode), .ser_in_lo(c_ser_up), .ser_in_hi(hi_tlo),
        .oe_a_n(1'b1), .oe_b_n(1'b1), .bus_in(c_bus), .bus_out(lo_out),
        .bus_drive(lo_drv), .tap_lo(lo_tlo), .tap_hi(lo_thi)
    );

    usr_shift_reg i_casc_hi (
        .clk(clk), .rst_n(rst_n), .mode(c_mode), .ser_in_lo(lo_thi), .ser_in_hi(c_ser_dn),
        .oe_a_n(1'b1), .oe_b_n(1'b1), .bus_in(c_bus), .bus_out(hi_out),
        .bus_drive(hi_drv), .tap_lo(hi_tlo), .tap_hi(hi_thi)
    );

    function automatic logic [7:0] ref_next(logic [7:0] cur, logic [1:0] m,
                                            logic s_up, logic s_dn, logic [7:0] b);
        case (m)
            2'b01:   return {cur[6:0], s_up};
            2'b10:   return {s_dn, cur[7:1]};
            2'b11:   return b;
            default: return cur;
        endcase
    endfunction

    function automatic logic ref_drive(logic a, logic b, logic [1:0] m);
        return (!a && !b && m != 2'b11);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string tag);
        chk(bus_out == model, tag, {8'h00, bus_out}, {8'h00, model});
        chk(tap_lo == model[0] && tap_hi == model[7], "R8 taps",
            {14'h0, tap_hi, tap_lo}, {14'h0, model[7], model[0]});
    endtask

    task automatic cycle(input logic [1:0] m, input logic s_up, input logic s_dn,
                         input logic [7:0] b, input logic a, input logic bb, input string tag);
        @(negedge clk);
        mode = m; sl = s_up; sh = s_dn; bus_in = b; oea = a; oeb = bb;
        #1;
        chk(bus_drive == ref_drive(a, bb, m), "R6 drive",
            {15'h0, bus_drive}, {15'h0, ref_drive(a, bb, m)});
        @(posedge clk);
        model = ref_next(model, m, s_up, s_dn, b);
        #1;
        check_outs(tag);
    endtask

    task automatic ccycle(input logic [1:0] m, input logic s_up, input logic s_dn,
                          input logic [7:0] b);
        @(negedge clk);
        c_mode = m; c_ser_up = s_up; c_ser_dn = s_dn; c_bus = b;
        @(posedge clk);
        case (m)
            2'b01:   cmodel = {cmodel[14:0], s_up};
            2'b10:   cmodel = {s_dn, cmodel[15:1]};
            2'b11:   cmodel = {b, b};
            default: cmodel = cmodel;
        endcase
        #1;
        chk({hi_out, lo_out} == cmodel, "R9 chain", {hi_out, lo_out}, cmodel);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        // R5: reset state
        repeat (3) @(posedge clk);
        #1;
        check_outs("R5 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // Directed cases
        cycle(2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, "R4 load");
        cycle(2'b00, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, "R1 hold");
        cycle(2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2 shift up");
        cycle(2'b10, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R3 shift down");
        chk(bus_out == 8'hA5, "R3 round trip", {8'h00, bus_out}, 16'h00A5);
        cycle(2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R7 shift up, drive off");
        cycle(2'b10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R7 shift down, drive off");
        cycle(2'b11, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b1, "R7 load, drive off");
        cycle(2'b00, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, "R7 hold, drive off");

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            cycle(m, 1'($urandom), 1'($urandom), 8'($urandom),
                  1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                  "R1 R2 R3 R4 R7 random");
        end

        // R5: reset in the middle of a cycle, no edge needed
        cycle(2'b11, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, "R4 load before reset");
        @(posedge clk);
        #3;
        mode = 2'b01; sl = 1'b1;
        rst_n = 1'b0;
        #1;
        model = 8'h00;
        check_outs("R5 mid-cycle clear");
        @(posedge clk);
        #1;
        check_outs("R5 held through edge");
        @(negedge clk);
        rst_n = 1'b1;

        // R9: 16-bit chain, both directions
        ccycle(2'b11, 1'b0, 1'b0, 8'h3C);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] pat;
            pat = 16'hB2E1;
            ccycle(2'b01, pat[15-i], 1'b0, 8'h00);
        end
        chk({hi_out, lo_out} == 16'hB2E1, "R9 up complete", {hi_out, lo_out}, 16'hB2E1);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] pat;
            pat = 16'h7D94;
            ccycle(2'b10, 1'b0, pat[i], 8'h00);
        end
        chk({hi_out, lo_out} == 16'h7D94, "R9 down complete", {hi_out, lo_out}, 16'h7D94);
        ccycle(2'b00, 1'b1, 1'b1, 8'hFF);

        finish_up();
    end
endmodule